// File: doc/BRIEF.md
# Write-Protected Output Source Selector

This block drives six general-purpose output pins. A select bit per pin picks its source. With the bit clear, the pin follows a bit of an output data register. With the bit set, the pin idles high and is pulled low for a short fixed pulse whenever the counter paired with it signals an overflow. Pins pair with counters in the order 0A, 0B, 1A, 1B, 2A, 2B, one counter overflow input per pin.

The select bits live in a control register that is protected by a lock. A separate lock register holds a write-enable bit. Control-register writes change nothing unless that bit is set. The one exception is the watchdog-clear bit: writing it as 1 always produces a single-cycle strobe, locked or not. The select bits do not appear when the control register is read. Software recovers them from three per-pair status registers, each of which shows the select of its A-counter output and of its B-counter output.

The register port is a plain single-cycle write strobe with an address and data. Reads are combinational from the address, so there is no data stream and no back-pressure. The overflow inputs are one-cycle event strobes.

Top module: `gpo_srcsel_top`

## Requirements
- R1: After reset the lock bit, all select bits, the output data register and the strobe are 0, so every pin follows its data bit, which is 0.
- R2: The lock register is at address 0, and bit 15 is its write-enable. That bit reads back as written. The other bits of the register read as 0.
- R3: While the lock bit is 0, a write to the control register (address 1) leaves every control bit other than 15 unchanged.
- R4: While the lock bit is 1, a write to the control register updates its bits on that clock edge. Bits 9:4 set the selects of pins 5:0 (bit 4+i selects for pin i).
- R5: A control write with bit 15 set raises `wd_clr` for exactly the one cycle after the write edge, whatever the lock state.
- R6: Reading the control register returns 0 in bits 9:4 and bit 15, and the stored value in the other bits.
- R7: A pin whose select is 0 drives bit i of the output data register. That register is at address 2, bits 5:0, and it is never locked.
- R8: For a pin whose select is 1, an overflow strobe sampled at an edge drives the pin low for exactly 8 cycles, starting with that edge. The pin is high at all other times.
- R9: An overflow that arrives during a pulse restarts it, so the pin stays low until 8 cycles after the latest overflow.
- R10: Status registers at addresses 4, 5 and 6 belong to counter pairs 0, 1 and 2. In each, bit 14 holds the select of the A-counter pin (2k), bit 13 holds the select of the B-counter pin (2k+1), and all other bits read 0.
- R11: An overflow on a pin whose select is 0 has no effect on that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cnt_ovf | input | 6 | Overflow strobe per paired counter |
| gpo | output | 6 | Output pin levels |
| wd_clr | output | 1 | One-cycle watchdog-clear strobe |

## Verification
Two functions can land in one cycle when a single locked control write carries both bit 15 and new select bits. The lock must discard the selects while the watchdog strobe still fires. The bench sends exactly that write. It then reads the strobe on the next cycle, and it reads the status registers and the pins to confirm the selects did not move. A second overlap is an overflow that arrives during a running pulse. The bench raises one mid-pulse and counts the low cycles that follow, which must reach the full eight.

// File: rtl/gpo_srcsel_pkg.sv
package gpo_srcsel_pkg;
  localparam int ADDR_W    = 3;
  localparam int REG_W     = 16;
  localparam logic [ADDR_W-1:0] A_LOCK     = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd1;
  localparam logic [ADDR_W-1:0] A_DOUT     = 3'd2;
  localparam logic [ADDR_W-1:0] A_PAIRBASE = 3'd4;
  localparam int LOCK_BIT  = 15;
  localparam int WDOG_BIT  = 15;
  localparam int SEL_LSB   = 4;
  localparam int MIR_A_BIT = 14;
  localparam int MIR_B_BIT = 13;
endpackage

// File: rtl/gpo_csr.sv
module gpo_csr
  import gpo_srcsel_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic [NUM_PINS-1:0] sel,
  output logic [NUM_PINS-1:0] dout,
  output logic                wd_clr
);
  localparam int NUM_PAIRS = NUM_PINS / 2;

  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    m = '1;
    for (int i = 0; i < NUM_PINS; i++) m[SEL_LSB+i] = 1'b0;
    m[WDOG_BIT] = 1'b0;
    return m;
  endfunction
  localparam logic [REG_W-1:0] KEEP_MASK = keep_mask();

  logic                lock_q;
  logic [REG_W-1:0]    misc_q;
  logic [NUM_PINS-1:0] sel_q;
  logic [NUM_PINS-1:0] dout_q;
  logic                wd_q;
  logic                wr_lock, wr_ctrl, wr_dout;

  assign wr_lock = bus_wr && (bus_addr == A_LOCK);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_dout = bus_wr && (bus_addr == A_DOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      misc_q <= '0;
      sel_q  <= '0;
      dout_q <= '0;
      wd_q   <= 1'b0;
    end else begin
      wd_q <= wr_ctrl && bus_wdata[WDOG_BIT];
      if (wr_lock) lock_q <= bus_wdata[LOCK_BIT];
      if (wr_dout) dout_q <= bus_wdata[NUM_PINS-1:0];
      if (wr_ctrl && lock_q) begin
        misc_q <= bus_wdata & KEEP_MASK;
        sel_q  <= bus_wdata[SEL_LSB +: NUM_PINS];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_LOCK) bus_rdata[LOCK_BIT] = lock_q;
    else if (bus_addr == A_CTRL) bus_rdata = misc_q;
    else if (bus_addr == A_DOUT) bus_rdata[NUM_PINS-1:0] = dout_q;
    else begin
      for (int k = 0; k < NUM_PAIRS; k++) begin
        if (bus_addr == A_PAIRBASE + ADDR_W'(k)) begin
          bus_rdata[MIR_A_BIT] = sel_q[2*k];
          bus_rdata[MIR_B_BIT] = sel_q[2*k+1];
        end
      end
    end
  end

  assign sel    = sel_q;
  assign dout   = dout_q;
  assign wd_clr = wd_q;

  // R3: a locked control write leaves the stored fields alone
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !lock_q) |=> ($stable(sel_q) && $stable(misc_q)));
  // R4: an unlocked control write lands its select field
  a_r4_unlocked_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && lock_q) |=> (sel_q == $past(bus_wdata[SEL_LSB +: NUM_PINS])));
  // R5: watchdog strobe follows any control write of bit 15
  a_r5_wd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[WDOG_BIT]) |=> wd_clr);
  a_r5_wd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_ctrl && bus_wdata[WDOG_BIT])) |=> !wd_clr);
endmodule

// File: rtl/gpo_pulse_stretch.sv
module gpo_pulse_stretch #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ovf,
  output logic pulling
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!arm)           cnt_q <= '0;
    else if (ovf)            cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulling = (cnt_q != '0);

  // R8: an armed overflow starts the pulse on the next cycle
  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && ovf) |=> pulling);
  // R11: a disarmed pin never pulses
  a_r11_idle_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm) |=> !pulling);

  // R9: a restart never stretches the count beyond its length
  always_comb begin
    if (rst_n) a_r9_len_bound: assert (cnt_q <= LOAD);
  end
endmodule

// File: rtl/gpo_srcsel_top.sv
module gpo_srcsel_top
  import gpo_srcsel_pkg::*;
#(
  parameter int NUM_PINS  = 6,
  parameter int PULSE_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] cnt_ovf,
  output logic [NUM_PINS-1:0] gpo,
  output logic                wd_clr
);
  logic [NUM_PINS-1:0] sel;
  logic [NUM_PINS-1:0] dout;
  logic [NUM_PINS-1:0] pulling;

  gpo_csr #(.NUM_PINS(NUM_PINS)) i_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel       (sel),
    .dout      (dout),
    .wd_clr    (wd_clr)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpo_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) i_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (sel[i]),
      .ovf     (cnt_ovf[i]),
      .pulling (pulling[i])
    );
    assign gpo[i] = sel[i] ? ~pulling[i] : dout[i];
  end
endmodule

// File: tb/test_gpo_srcsel_top.sv
module test_gpo_srcsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [5:0]  cnt_ovf = '0;
  logic [5:0]  gpo;
  logic        wd_clr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpo_srcsel_top i_gpo_srcsel_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_ovf(cnt_ovf),
    .gpo(gpo), .wd_clr(wd_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); check(v == 16'h0, "R1 lock", v, 0);
    rd(3'd1, v); check(v == 16'h0, "R1 ctrl", v, 0);
    rd(3'd4, v); check(v == 16'h0, "R1 pair0", v, 0);
    check(gpo == 6'h0, "R1 gpo", gpo, 0);
    check(wd_clr == 1'b0, "R1 wd_clr", wd_clr, 0);
  endtask

  task automatic t_lock_reg();
    logic [15:0] v;
    wr(3'd0, 16'hFFFF); rd(3'd0, v); check(v == 16'h8000, "R2 set", v, 16'h8000);
    wr(3'd0, 16'h7FFF); rd(3'd0, v); check(v == 16'h0, "R2 clear", v, 0);
  endtask

  task automatic t_plain();
    wr(3'd2, 16'h0016);
    check(gpo == 6'h16, "R7 plain pins", gpo, 6'h16);
    cnt_ovf = 6'h3F;
    @(negedge clk); cnt_ovf = '0;
    check(gpo == 6'h16, "R11 ovf ignored", gpo, 6'h16);
  endtask

  task automatic t_locked_write();
    logic [15:0] v;
    wr(3'd1, 16'hFE9F);
    check(wd_clr == 1'b1, "R5 strobe while locked", wd_clr, 1);
    rd(3'd1, v); check(v == 16'h0, "R3 ctrl unchanged", v, 0);
    rd(3'd4, v); check(v == 16'h0, "R3 pair0 unchanged", v, 0);
    check(gpo == 6'h16, "R3 pins unchanged", gpo, 6'h16);
    @(negedge clk);
    check(wd_clr == 1'b0, "R5 one cycle", wd_clr, 0);
  endtask

  task automatic t_unlocked_write();
    logic [15:0] v;
    wr(3'd0, 16'h8000);
    wr(3'd1, 16'h7E9F);
    check(wd_clr == 1'b0, "R5 no strobe without bit15", wd_clr, 0);
    rd(3'd1, v); check(v == 16'h7C0F, "R6 ctrl read", v, 16'h7C0F);
    rd(3'd4, v); check(v == 16'h4000, "R10 pair0", v, 16'h4000);
    rd(3'd5, v); check(v == 16'h2000, "R10 pair1", v, 16'h2000);
    rd(3'd6, v); check(v == 16'h2000, "R10 pair2", v, 16'h2000);
    check(gpo == 6'h3F, "R4 selects live", gpo, 6'h3F);
    wr(3'd1, 16'h8290);
    check(wd_clr == 1'b1, "R5 strobe unlocked", wd_clr, 1);
    rd(3'd1, v); check(v == 16'h0, "R6 ctrl after rewrite", v, 0);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0000);
    check(gpo == 6'h29, "R7 sel0 pins low", gpo, 6'h29);
  endtask

  task automatic t_pulse();
    @(negedge clk); cnt_ovf = 6'b000011;
    @(negedge clk); cnt_ovf = '0;
    check(gpo == 6'h28, "R8 low first cycle", gpo, 6'h28);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check(gpo == 6'h28, "R8 low hold", gpo, 6'h28);
    end
    @(negedge clk);
    check(gpo == 6'h29, "R8 release", gpo, 6'h29);
  endtask

  task automatic t_restart();
    @(negedge clk); cnt_ovf = 6'b001000;
    @(negedge clk); cnt_ovf = '0;
    for (int i = 0; i < 2; i++) @(negedge clk);
    check(gpo == 6'h21, "R9 first pulse low", gpo, 6'h21);
    cnt_ovf = 6'b001000;
    @(negedge clk); cnt_ovf = '0;
    for (int i = 0; i < 7; i++) begin
      check(gpo == 6'h21, "R9 restarted low", gpo, 6'h21);
      @(negedge clk);
    end
    check(gpo == 6'h21, "R9 eighth low", gpo, 6'h21);
    @(negedge clk);
    check(gpo == 6'h29, "R9 release", gpo, 6'h29);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_reg();
    t_plain();
    t_locked_write();
    t_unlocked_write();
    t_pulse();
    t_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule